// File: doc/BRIEF.md
# Leveled Interrupt Priority Masker

This block sits between a set of prioritized interrupt request lines and a processor core. Each of seven request lines owns one priority level: line k carries level k+1, so the top line is level 7. The core supplies a 3-bit current mask level and a per-line enable vector. The block reports whether an unmasked request is waiting, together with the encoded level of the highest one.

Lines at levels 1 to 6 are level-sensitive, and the mask level inhibits them. The level 7 line is captured on its rising edge into a latch. The mask level cannot block it. The latch holds until an acknowledge returns level 7.

An acknowledge pulse returns the level being serviced in the same cycle. If no unmasked, enabled request remains at acknowledge time, the pulse returns a spurious flag instead. This happens, for example, when software disables a line after it was presented.

A separate wakeup comparator runs without a clock. It compares the raw enabled lines against a wakeup mask level. That mask level is limited to at most 6, so a level 7 request can always wake the device.

Top module: `intc_level_masker`

## Requirements
- R1: After reset the level 7 latch is empty. With all lines low, pend_o, pend_lvl_o, ack_lvl_o, ack_spur_o and wake_o are all 0. Asserting reset clears a captured level 7 request.
- R2: A line at level L in 1..6 (irq_i bit L-1) with its enable bit set counts as pending only while the line is high and L is greater than mask_lvl_i.
- R3: pend_lvl_o is the highest level among the pending requests, and is 0 when pend_o is 0.
- R4: A low-to-high transition on irq_i[6] becomes pending on the clock edge that samples it high. It stays pending after the line falls, whatever mask_lvl_i is.
- R5: An acknowledge that returns level 7 empties the level 7 latch on that clock edge. Holding the line high afterwards does not capture it again.
- R6: Clearing a bit of src_en_i removes that line from pending and from wakeup. The enable vector applies to all seven lines.
- R7: While ack_i is high and a request is pending, ack_lvl_o equals pend_lvl_o in the same cycle and ack_spur_o is 0.
- R8: While ack_i is high and nothing is pending, ack_spur_o is 1 and ack_lvl_o is 0. ack_spur_o is 0 whenever ack_i is low.
- R9: wake_o is 1, with no clock edge needed, exactly when an enabled raw line at level L satisfies L greater than min(wake_lvl_i, 6).
- R10: A wake_lvl_i of 7 behaves as 6, so an enabled high level 7 line always drives wake_o to 1.
- R11: A mask_lvl_i of 7 blocks levels 1 to 6 but not a captured level 7 request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 7 | Request lines; bit k is level k+1 |
| src_en_i | input | 7 | Per-line enable, 1 = enabled |
| mask_lvl_i | input | 3 | Current mask level |
| wake_lvl_i | input | 3 | Wakeup mask level, limited to 6 internally |
| ack_i | input | 1 | One-cycle acknowledge pulse |
| pend_o | output | 1 | An unmasked enabled request is pending |
| pend_lvl_o | output | 3 | Highest pending level, 0 if none |
| ack_lvl_o | output | 3 | Level returned by the acknowledge |
| ack_spur_o | output | 1 | Acknowledge found no pending request |
| wake_o | output | 1 | Unclocked wakeup request |

## Verification
The hardest state to reach is an acknowledge that finds nothing pending right after a request was visible. The stimulus first makes a level 3 request pending. It then clears that line's enable bit between negative and positive clock edges and pulses acknowledge in the same cycle, expecting the spurious flag.

A second hard case is a level 7 line still held high after its acknowledge. The bench keeps the line up across the clearing edge and confirms that nothing is captured again.

The combinational paths are swept exhaustively over every level 1 to 6 request pattern, every mask level, every wakeup level and two enable patterns.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;

    // State of the top-level edge capture
    typedef struct packed {
        logic prev;   // line value seen on the previous edge
        logic lat;    // captured, not yet acknowledged
    } nmi_state_t;

    // prev resets high so a line already high at reset release is not an edge
    localparam nmi_state_t NMI_RST = '{prev: 1'b1, lat: 1'b0};

endpackage

// File: rtl/intc_nmi_edge.sv
`timescale 1ns/1ps
module intc_nmi_edge
    import intc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic clr_i,
    output logic lat_o
);

    nmi_state_t st_d, st_q;
    logic       rise;

    always_comb begin
        rise      = line_i & ~st_q.prev;
        st_d.prev = line_i;
        // a fresh edge wins over a clear in the same cycle
        st_d.lat  = rise | (st_q.lat & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= NMI_RST;
        else        st_q <= st_d;
    end

    assign lat_o = st_q.lat;

    AST_L7_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (line_i && !st_q.prev) |=> st_q.lat); // R4
    AST_L7_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lat && !clr_i) |=> st_q.lat); // R4
    AST_L7_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(line_i && !st_q.prev)) |=> !st_q.lat); // R5

endmodule

// File: rtl/intc_prio_enc.sv
`timescale 1ns/1ps
module intc_prio_enc #(
    parameter int NUM_LVL = 7,
    parameter int LVL_W   = $clog2(NUM_LVL + 1)
) (
    input  logic [NUM_LVL-1:0] req_i,
    input  logic [LVL_W-1:0]   mask_i,
    output logic               pend_o,
    output logic [LVL_W-1:0]   lvl_o
);

    logic [NUM_LVL-1:0] live;

    // per-level gate: the top level ignores the mask level
    for (genvar k = 0; k < NUM_LVL; k++) begin : g_gate
        if (k == NUM_LVL - 1) begin : g_top
            assign live[k] = req_i[k];
        end else begin : g_masked
            assign live[k] = req_i[k] & (LVL_W'(k + 1) > mask_i);
        end
    end

    always_comb begin
        lvl_o = '0;
        for (int k = 0; k < NUM_LVL; k++) begin
            if (live[k]) lvl_o = LVL_W'(k + 1);
        end
        pend_o = |live;
    end

endmodule

// File: rtl/intc_wake_cmp.sv
`timescale 1ns/1ps
module intc_wake_cmp #(
    parameter int NUM_LVL = 7,
    parameter int LVL_W   = $clog2(NUM_LVL + 1)
) (
    input  logic [NUM_LVL-1:0] raw_i,
    input  logic [NUM_LVL-1:0] en_i,
    input  logic [LVL_W-1:0]   wake_lvl_i,
    output logic               wake_o
);

    localparam logic [LVL_W-1:0] LIM_MAX = LVL_W'(NUM_LVL - 1);

    logic [LVL_W-1:0]   lim;
    logic [NUM_LVL-1:0] above;

    assign lim = (wake_lvl_i > LIM_MAX) ? LIM_MAX : wake_lvl_i;

    for (genvar k = 0; k < NUM_LVL; k++) begin : g_cmp
        assign above[k] = raw_i[k] & en_i[k] & (LVL_W'(k + 1) > lim);
    end

    assign wake_o = |above;

endmodule

// File: rtl/intc_level_masker.sv
`timescale 1ns/1ps
module intc_level_masker #(
    parameter int NUM_LVL = 7,
    parameter int LVL_W   = $clog2(NUM_LVL + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LVL-1:0] irq_i,
    input  logic [NUM_LVL-1:0] src_en_i,
    input  logic [LVL_W-1:0]   mask_lvl_i,
    input  logic [LVL_W-1:0]   wake_lvl_i,
    input  logic               ack_i,
    output logic               pend_o,
    output logic [LVL_W-1:0]   pend_lvl_o,
    output logic [LVL_W-1:0]   ack_lvl_o,
    output logic               ack_spur_o,
    output logic               wake_o
);

    localparam int               TOP     = NUM_LVL - 1;
    localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(NUM_LVL);

    logic               top_lat;
    logic               top_clr;
    logic [NUM_LVL-1:0] eff_req;

    // effective request vector: levels below the top are level-sensitive
    always_comb begin
        eff_req      = irq_i & src_en_i;
        eff_req[TOP] = top_lat & src_en_i[TOP];
    end

    assign top_clr = ack_i & pend_o & (pend_lvl_o == TOP_LVL);

    intc_nmi_edge i_nmi (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (irq_i[TOP]),
        .clr_i  (top_clr),
        .lat_o  (top_lat)
    );

    intc_prio_enc #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) i_enc (
        .req_i  (eff_req),
        .mask_i (mask_lvl_i),
        .pend_o (pend_o),
        .lvl_o  (pend_lvl_o)
    );

    intc_wake_cmp #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) i_wake (
        .raw_i      (irq_i),
        .en_i       (src_en_i),
        .wake_lvl_i (wake_lvl_i),
        .wake_o     (wake_o)
    );

    assign ack_lvl_o  = ack_i ? pend_lvl_o : '0;
    assign ack_spur_o = ack_i & ~pend_o;

    AST_TOP_NONMASK: assert property (@(posedge clk) disable iff (!rst_n)
        (top_lat && src_en_i[TOP]) |-> (pend_lvl_o == TOP_LVL)); // R11
    AST_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && pend_lvl_o != TOP_LVL) |-> (pend_lvl_o > mask_lvl_i)); // R2
    AST_SPUR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ack_spur_o |-> (ack_lvl_o == '0 && ack_i)); // R8
    AST_WAKE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_i[TOP] && src_en_i[TOP]) |-> wake_o); // R10
    AST_PEND_LVL: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_o |-> (pend_lvl_o == '0)); // R3

endmodule

// File: tb/test_intc_level_masker.sv
`timescale 1ns/1ps
module test_intc_level_masker;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] irq = '0;
    logic [6:0] en = '0;
    logic [2:0] mask = '0;
    logic [2:0] wl = '0;
    logic       ack = 1'b0;
    logic       pend, spur, wake;
    logic [2:0] plvl, alvl;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    intc_level_masker i_intc_level_masker (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .src_en_i(en),
        .mask_lvl_i(mask), .wake_lvl_i(wl), .ack_i(ack),
        .pend_o(pend), .pend_lvl_o(plvl), .ack_lvl_o(alvl),
        .ack_spur_o(spur), .wake_o(wake)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_lvl(input logic [6:0] r, input logic [6:0] e, input int m);
        int best = 0;
        for (int k = 0; k < 6; k++) if (r[k] && e[k] && (k + 1) > m) best = k + 1;
        return best;
    endfunction

    function automatic int exp_wake(input logic [6:0] r, input logic [6:0] e, input int w);
        int lim = (w > 6) ? 6 : w;
        int hit = 0;
        for (int k = 0; k < 7; k++) if (r[k] && e[k] && (k + 1) > lim) hit = 1;
        return hit;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pend", pend, 0); chk("R1 lvl", plvl, 0);
        chk("R1 ack_lvl", alvl, 0); chk("R1 spur", spur, 0); chk("R1 wake", wake, 0);

        // R2 R3 R6 R9 exhaustive sweep of levels 1..6
        for (int ep = 0; ep < 2; ep++) begin
            for (int r = 0; r < 64; r++) begin
                for (int m = 0; m < 8; m++) begin
                    for (int w = 0; w < 8; w++) begin
                        en = (ep == 0) ? 7'h7F : 7'h55;
                        irq = 7'(r); mask = 3'(m); wl = 3'(w);
                        #1;
                        chk("R2 pend", pend, (exp_lvl(irq, en, m) != 0) ? 1 : 0);
                        chk("R3 lvl", plvl, exp_lvl(irq, en, m));
                        chk("R9 wake", wake, exp_wake(irq, en, w));
                    end
                end
            end
        end

        // R4 R11 level 7 capture under full mask
        @(negedge clk);
        irq = '0; en = 7'h7F; mask = 3'd7; wl = 3'd0;
        @(negedge clk);
        irq = 7'h40;
        @(negedge clk);
        chk("R11 pend", pend, 1); chk("R4 lvl", plvl, 7);
        irq = 7'h00;
        @(negedge clk);
        chk("R4 held", plvl, 7);
        ack = 1'b1; #1;
        chk("R7 ack_lvl", alvl, 7); chk("R7 spur", spur, 0);
        @(negedge clk);
        ack = 1'b0; #1;
        chk("R5 cleared", pend, 0);

        // R5 no retrigger while line stays high
        irq = 7'h40;
        @(negedge clk);
        ack = 1'b1; #1;
        chk("R5 ack_lvl", alvl, 7);
        @(negedge clk);
        ack = 1'b0;
        @(negedge clk);
        chk("R5 no_retrig", pend, 0);
        irq = 7'h00;
        @(negedge clk);

        // R3 level 7 over level 3, then level 3 remains
        mask = 3'd2; irq = 7'h04;
        @(negedge clk);
        irq = 7'h44;
        @(negedge clk);
        chk("R3 top", plvl, 7);
        ack = 1'b1; #1;
        chk("R7 ack7", alvl, 7);
        @(negedge clk);
        ack = 1'b0; #1;
        chk("R3 next", plvl, 3);

        // R8 spurious: source disabled before acknowledge
        irq = 7'h04;
        en = 7'h7B; ack = 1'b1; #1;
        chk("R8 spur", spur, 1); chk("R8 ack_lvl", alvl, 0);
        @(negedge clk);
        ack = 1'b0; #1;
        chk("R8 spur_idle", spur, 0);

        // R10 clamp lets level 7 wake; R6 enable removes it
        irq = 7'h40; en = 7'h7F; wl = 3'd7; #1;
        chk("R10 wake", wake, 1);
        en = 7'h3F; #1;
        chk("R6 wake_off", wake, 0);
        en = 7'h7F;
        @(negedge clk);
        chk("R4 latched", plvl, 7);

        // R1 reset empties the latch
        rst_n = 1'b0; #1;
        chk("R1 rst_clear", pend, 0);
        irq = '0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after", pend, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule